// File: doc/BRIEF.md
# Phase-Selectable Strobed Word Transfer Between Related Clocks

This block moves parallel words from a fast source clock to a slower destination clock. The two clocks share a common base period, and the block needs no FIFO and no synchronizer chain. In the source domain, one or more serial lanes are deserialized. The assembled word is reloaded only once per base period and then held unchanged for a full base period. In the destination domain, a free-running one-hot ring marks each destination cycle position within the base period. A multiplexer chooses one ring tap as a one-cycle capture enable. Because the enable fires exactly once per base period, every capture sees a word that has had a whole base period to settle. The path therefore behaves like a single-clock path running at the base rate.

The capture slot can be changed at run time through a plain control input. This lets integration move the capture instant to wherever the source word is safely stable. The reset slot is the middle position. Phase changes are applied only at a base-period boundary, so a period never loses its capture and never gets two. The captured word leaves on a valid-only stream: `cap_valid` marks each new word and there is no ready input. The transfer is paced by the clocks, so it has no back-pressure, and the sink must take each word in the cycle where `cap_valid` is high.

The default ratio is 8 source cycles and 6 destination cycles per base period. Two serial lanes give a 16-bit word.

Top module: `strobed_xfer`

## Requirements
- R1: While either reset is low, and right after its release, `cap_data` is 0 and `cap_valid` is 0. The capture slot after reset is DEFAULT_PHASE (3).
- R2: Each lane shifts in one bit per source cycle, most significant bit first. The first bit is the one sampled on the first source edge after reset release. Lane l fills `cap_data[l*SRC_RATIO +: SRC_RATIO]`.
- R3: The source word is reloaded only on the SRC_RATIO-th source cycle of each base period, and is held for the full base period in between.
- R4: Every captured word equals the last source word completed before the capturing destination edge.
- R5: A capture happens on the destination edge at slot `phase_sel` of the base period, that is, `phase_sel` destination cycles after the period boundary.
- R6: Exactly one capture happens in every window of DST_RATIO destination cycles that starts at slot 0.
- R7: A new `phase_sel` value takes effect only at the next base-period boundary. The period in progress keeps its old slot.
- R8: `phase_sel` values of DST_RATIO or more are ignored. The slot in use stays as it was.
- R9: `cap_valid` is high for exactly the one destination cycle that follows the edge that loaded `cap_data`. At all other times `cap_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source clock, SRC_RATIO cycles per base period |
| src_rst_n | input | 1 | Source-domain reset, active low |
| ser_in | input | LANES | Serial data, one bit per lane per source cycle |
| dst_clk | input | 1 | Destination clock, DST_RATIO cycles per base period |
| dst_rst_n | input | 1 | Destination-domain reset, active low |
| phase_sel | input | $clog2(DST_RATIO) | Requested capture slot, destination domain |
| cap_data | output | LANES*SRC_RATIO | Captured word |
| cap_valid | output | 1 | One-cycle marker of a newly captured word |

## Verification
The assertions check the following on every cycle:
- The source word changes only at the end of a base period.
- The ring always has exactly one bit set.
- Each ring revolution yields a single capture enable.
- The slot register changes only at a boundary, holds a legal value, and ignores out-of-range requests.
- `cap_data` never changes unless `cap_valid` follows.

The following can only be shown by the bench's scenarios, using a reference model that runs in step with both clocks:
- Each captured word is the correctly ordered, MSB-first word sent in the matching period.
- The capture lands in the requested slot for every phase value.
- Mid-period and illegal phase requests change the slot only at the boundary, or not at all.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  // Default frequency ratios per base period and lane count
  localparam int unsigned DEF_SRC_RATIO = 8;
  localparam int unsigned DEF_DST_RATIO = 6;
  localparam int unsigned DEF_LANES     = 2;
  localparam int unsigned DEF_PHASE     = 3;

  // Width of a slot index for a given ratio (at least one bit)
  function automatic int unsigned slot_w(input int unsigned ratio);
    return (ratio > 1) ? $clog2(ratio) : 1;
  endfunction
endpackage

// File: rtl/xfer_deser.sv
module xfer_deser #(
  parameter int unsigned SRC_RATIO = xfer_pkg::DEF_SRC_RATIO,
  parameter int unsigned LANES     = xfer_pkg::DEF_LANES,
  localparam int unsigned CNT_W    = xfer_pkg::slot_w(SRC_RATIO),
  localparam int unsigned WORD_W   = LANES * SRC_RATIO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  ser_in,
  output logic [WORD_W-1:0] word_q
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SRC_RATIO - 1);

  logic [CNT_W-1:0] bit_cnt_q;
  logic             load;

  assign load = (bit_cnt_q == LAST_BIT);

  // Shared position counter within the base period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bit_cnt_q <= '0;
    else if (load) bit_cnt_q <= '0;
    else           bit_cnt_q <= bit_cnt_q + 1'b1;
  end

  // One shift register and one holding field per lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SRC_RATIO-1:0] shift_q;
    logic [SRC_RATIO-1:0] next_word;

    assign next_word = {shift_q[SRC_RATIO-2:0], ser_in[l]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shift_q <= '0;
      else        shift_q <= next_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word_q[l*SRC_RATIO +: SRC_RATIO] <= '0;
      else if (load) word_q[l*SRC_RATIO +: SRC_RATIO] <= next_word;
    end
  end
endmodule

// File: rtl/xfer_phase_ring.sv
module xfer_phase_ring #(
  parameter int unsigned DST_RATIO     = xfer_pkg::DEF_DST_RATIO,
  parameter int unsigned DEFAULT_PHASE = xfer_pkg::DEF_PHASE,
  localparam int unsigned SEL_W        = xfer_pkg::slot_w(DST_RATIO)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_W-1:0]     phase_sel,
  output logic [DST_RATIO-1:0] ring_q,
  output logic [SEL_W-1:0]     sel_q,
  output logic                 strobe
);
  localparam logic [SEL_W-1:0] LAST_SLOT = SEL_W'(DST_RATIO - 1);

  logic                 boundary;
  logic [DST_RATIO-1:0] tap_hit;

  // Circulating single pulse, one position per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= DST_RATIO'(1);
    else        ring_q <= {ring_q[DST_RATIO-2:0], ring_q[DST_RATIO-1]};
  end

  assign boundary = ring_q[DST_RATIO-1];

  // Slot register: loads only on the last slot, legal requests only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel_q <= SEL_W'(DEFAULT_PHASE);
    else if (boundary && (phase_sel <= LAST_SLOT))
      sel_q <= phase_sel;
  end

  // AND-OR tap multiplexer
  for (genvar i = 0; i < DST_RATIO; i++) begin : g_tap
    assign tap_hit[i] = ring_q[i] & (sel_q == SEL_W'(i));
  end

  assign strobe = |tap_hit;
endmodule

// File: rtl/xfer_capture.sv
module xfer_capture #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [WORD_W-1:0] src_word,
  output logic [WORD_W-1:0] cap_data,
  output logic              cap_valid
);
  // Destination register fed straight from the held source word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_data <= '0;
    else if (cap_en) cap_data <= src_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_valid <= 1'b0;
    else        cap_valid <= cap_en;
  end
endmodule

// File: rtl/strobed_xfer.sv
module strobed_xfer #(
  parameter int unsigned SRC_RATIO     = xfer_pkg::DEF_SRC_RATIO,
  parameter int unsigned DST_RATIO     = xfer_pkg::DEF_DST_RATIO,
  parameter int unsigned LANES         = xfer_pkg::DEF_LANES,
  parameter int unsigned DEFAULT_PHASE = xfer_pkg::DEF_PHASE,
  localparam int unsigned SEL_W        = xfer_pkg::slot_w(DST_RATIO),
  localparam int unsigned WORD_W       = LANES * SRC_RATIO
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic [LANES-1:0]  ser_in,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  input  logic [SEL_W-1:0]  phase_sel,
  output logic [WORD_W-1:0] cap_data,
  output logic              cap_valid
);
  logic [WORD_W-1:0]    src_word;
  logic [DST_RATIO-1:0] ring;
  logic [SEL_W-1:0]     sel_q;
  logic                 cap_en;

  xfer_deser #(.SRC_RATIO(SRC_RATIO), .LANES(LANES)) u_deser (
    .clk    (src_clk),
    .rst_n  (src_rst_n),
    .ser_in (ser_in),
    .word_q (src_word)
  );

  xfer_phase_ring #(.DST_RATIO(DST_RATIO), .DEFAULT_PHASE(DEFAULT_PHASE)) u_ring (
    .clk       (dst_clk),
    .rst_n     (dst_rst_n),
    .phase_sel (phase_sel),
    .ring_q    (ring),
    .sel_q     (sel_q),
    .strobe    (cap_en)
  );

  xfer_capture #(.WORD_W(WORD_W)) u_cap (
    .clk       (dst_clk),
    .rst_n     (dst_rst_n),
    .cap_en    (cap_en),
    .src_word  (src_word),
    .cap_data  (cap_data),
    .cap_valid (cap_valid)
  );
endmodule

// File: rtl/strobed_xfer_chk.sv
module strobed_xfer_chk #(
  parameter int unsigned SRC_RATIO = 8,
  parameter int unsigned DST_RATIO = 6,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned WORD_W    = 16
) (
  input logic                 src_clk,
  input logic                 src_rst_n,
  input logic                 dst_clk,
  input logic                 dst_rst_n,
  input logic [WORD_W-1:0]    src_word,
  input logic [DST_RATIO-1:0] ring,
  input logic [SEL_W-1:0]     sel_q,
  input logic [SEL_W-1:0]     phase_sel,
  input logic                 cap_en,
  input logic [WORD_W-1:0]    cap_data,
  input logic                 cap_valid
);
  localparam int unsigned     CW        = $clog2(SRC_RATIO) + 1;
  localparam logic [SEL_W-1:0] LAST_SLOT = SEL_W'(DST_RATIO - 1);

  // Independent count of source cycles since reset, modulo the ratio
  logic [CW-1:0] src_pos_q;
  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n)                               src_pos_q <= '0;
    else if (src_pos_q == CW'(SRC_RATIO - 1))     src_pos_q <= '0;
    else                                          src_pos_q <= src_pos_q + 1'b1;
  end

  // Enables seen so far in the current ring revolution
  logic [2:0] acc_q;
  logic [2:0] total;
  assign total = (ring[0] ? 3'd0 : acc_q) + {2'b00, cap_en};
  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) acc_q <= '0;
    else            acc_q <= total;
  end

  AST_SRC_WORD_HELD: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !$stable(src_word) |-> ($past(src_pos_q) == CW'(SRC_RATIO - 1)));  // R3

  AST_RING_ONE_HOT: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $countones(ring) == 1);  // R6

  AST_ONE_STROBE_PER_PERIOD: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    ring[DST_RATIO-1] |-> (total == 3'd1));  // R6

  AST_SLOT_MOVES_AT_BOUNDARY: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !$past(ring[DST_RATIO-1]) |-> $stable(sel_q));  // R7

  AST_SLOT_LEGAL: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    sel_q <= LAST_SLOT);  // R8

  AST_ILLEGAL_REQUEST_IGNORED: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    ($past(ring[DST_RATIO-1]) && ($past(phase_sel) > LAST_SLOT)) |-> $stable(sel_q));  // R8

  AST_DATA_CHANGE_FLAGGED: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !$stable(cap_data) |-> cap_valid);  // R9

  AST_VALID_AFTER_ENABLE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    cap_en |=> cap_valid);  // R9
endmodule

bind strobed_xfer strobed_xfer_chk #(
  .SRC_RATIO (SRC_RATIO),
  .DST_RATIO (DST_RATIO),
  .SEL_W     (SEL_W),
  .WORD_W    (WORD_W)
) chk_i (
  .src_clk   (src_clk),
  .src_rst_n (src_rst_n),
  .dst_clk   (dst_clk),
  .dst_rst_n (dst_rst_n),
  .src_word  (src_word),
  .ring      (ring),
  .sel_q     (sel_q),
  .phase_sel (phase_sel),
  .cap_en    (cap_en),
  .cap_data  (cap_data),
  .cap_valid (cap_valid)
);

// File: tb/strobed_xfer_tb_top.sv
`timescale 1ns/1ps
module strobed_xfer_tb_top;
  localparam int      SR = 8;
  localparam int      DR = 6;
  localparam int      LN = 2;
  localparam int      W  = SR * LN;
  localparam realtime BASE_PERIOD = 24.0;
  localparam realtime SRC_HALF    = BASE_PERIOD / (2.0 * SR);
  localparam realtime DST_HALF    = BASE_PERIOD / (2.0 * DR);
  localparam realtime DST_PERIOD  = 2.0 * DST_HALF;
  localparam realtime REL_TIME    = 4.0 * BASE_PERIOD;

  logic          src_clk, dst_clk, src_rst_n, dst_rst_n;
  logic [LN-1:0] ser_in;
  logic [2:0]    phase_sel;
  logic [W-1:0]  cap_data;
  logic          cap_valid;

  int vectors = 0;
  int errors  = 0;

  strobed_xfer dut_i (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .ser_in(ser_in),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .phase_sel(phase_sel),
    .cap_data(cap_data), .cap_valid(cap_valid)
  );

  // Both clocks rise together at every base-period boundary
  initial begin src_clk = 1'b1; forever #(SRC_HALF) src_clk = ~src_clk; end
  initial begin dst_clk = 1'b1; forever #(DST_HALF) dst_clk = ~dst_clk; end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // Serial stimulus, changed away from sampling edges
  always @(negedge src_clk) ser_in <= LN'($urandom);

  // Source reference: collect bits MSB first per lane
  logic [W-1:0] m_shift = '0;
  logic [W-1:0] m_latest = '0;
  int           m_bits = 0;
  always @(posedge src_clk) begin
    if (src_rst_n) begin
      for (int l = 0; l < LN; l++)
        m_shift[l*SR +: SR] = {m_shift[l*SR +: SR-1], ser_in[l]};
      m_bits++;
      if (m_bits == SR) begin
        m_latest = m_shift;
        m_bits   = 0;
      end
    end
  end

  // Destination reference: slot position, slot in use, expected outputs
  int           m_pos = 0;
  int           m_sel = 3;
  int           cap_slot = 0;
  int           win_caps = 0;
  bit           first_cap = 1;
  logic [W-1:0] e_data = '0;
  logic         e_valid = 1'b0;

  always @(posedge dst_clk) begin
    if (dst_rst_n) begin
      if (m_pos == 0) win_caps = 0;
      if (m_pos == m_sel) begin
        e_data   = m_latest;
        e_valid  = 1'b1;
        cap_slot = m_pos;
        win_caps++;
      end else begin
        e_valid = 1'b0;
      end
      if (m_pos == DR - 1) begin
        check("R6 one capture per period", W'(win_caps), W'(1));
        if (int'(phase_sel) < DR) m_sel = int'(phase_sel);  // R7 boundary, R8 ignore
      end
      m_pos = (m_pos + 1) % DR;
      #1;
      // R2/R4: data compare; R3: each captured word must be a fully held word
      check("R2/R4 captured word", cap_data, e_data);
      check("R9 valid strobe", W'(cap_valid), W'(e_valid));
      if (cap_valid === 1'b1) begin
        int slot_seen;
        slot_seen = int'(($realtime - 1.0 - REL_TIME) / DST_PERIOD) % DR;
        check("R5 capture slot", W'(slot_seen), W'(cap_slot));
        if (first_cap) begin
          check("R1 default slot after reset", W'(slot_seen), W'(3));
          first_cap = 0;
        end
      end
    end
  end

  task automatic wait_periods(input int n);
    repeat (n * DR) @(negedge dst_clk);
  endtask

  initial begin
    src_rst_n = 1'b0; dst_rst_n = 1'b0; phase_sel = 3'd3; ser_in = '0;
    #(REL_TIME / 2.0);
    check("R1 reset data", cap_data, '0);
    check("R1 reset valid", W'(cap_valid), W'(0));
    #(REL_TIME / 2.0 - 1.0);
    src_rst_n = 1'b1; dst_rst_n = 1'b1;
    #0.5;
    check("R1 data after release", cap_data, '0);
    wait_periods(6);
    // R5: every legal slot in turn
    for (int s = 0; s < DR; s++) begin
      phase_sel = 3'(s);
      wait_periods(5);
    end
    // R7: requests changed mid-period, several times
    for (int k = 0; k < 8; k++) begin
      repeat (k % 5 + 1) @(negedge dst_clk);
      phase_sel = 3'((k * 5 + 1) % DR);
      repeat (7) @(negedge dst_clk);
    end
    wait_periods(3);
    // R8: out-of-range requests keep the current slot
    phase_sel = 3'd2;
    wait_periods(3);
    phase_sel = 3'd7;
    wait_periods(4);
    phase_sel = 3'd6;
    wait_periods(4);
    phase_sel = 3'd0;
    wait_periods(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(BASE_PERIOD * 5000.0);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule